// File: doc/BRIEF.md
# Programmable-Latency Search Result Output Stage

This block sits at the edge of a search device and returns three per-search signals to the host: a hit flag, a valid flag and an SRAM read acknowledge. A configurable number of extra clock cycles, from 0 to 7, is added to all three. The host sets this number to cover the delay between the address going out to external SRAM and the data coming back. With the right setting, the flags and the SRAM data reach the host in the same cycle.

The block also decides when this device drives the shared cascade wires. The device marked as last in the depth cascade drives default flag values when no other device has a result. The device marked as last on the SRAM bus drives a default address and inactive strobes when nobody else uses the bus. It also always drives the SRAM output-enable strobe. A device-enable bit releases every shared output, forces the cascade outputs low and keeps the data bus as an input. This prevents bus contention while the system powers up.

Top module: `result_flag_stage`

## Requirements
- R1: A search result sampled at a clock edge appears on `flag_hit`/`flag_vld` right after the edge `L` cycles later, where `L` is the unsigned value of `cfg_extra_lat` (0..7). This holds while `cfg_extra_lat` has not changed since that result was sampled.
- R2: An SRAM read acknowledge on `rd_ack_in` reaches `ack_o` with the same latency as R1.
- R3: A search with a hit in this device (`srch_done`=1, `srch_hit`=1) is delivered as `flag_hit`=1, `flag_vld`=1, with `flag_oe`=1 when the device is enabled.
- R4: When `cfg_last_cascade`=1, a failed search (`srch_done`=1, `srch_hit`=0) is delivered as `flag_hit`=0, `flag_vld`=1, with `flag_oe`=1.
- R5: When `cfg_last_cascade`=1, a delivery slot with no search gives `flag_hit`=0, `flag_vld`=0, with `flag_oe`=1.
- R6: When `cfg_last_cascade`=0, a delivery slot without a hit of this device gives `flag_oe`=0, `flag_hit`=0 and `flag_vld`=0.
- R7: When `cfg_last_sram`=1 and `sram_drv`=0, the enabled device sets `sram_bus_oe`=1, `sram_addr_o`=22'h3FFFFF, and drives `sram_ce_n_o`, `sram_we_n_o` and `sram_ale_n_o` to 1. When `sram_drv`=1, these outputs pass the core's values through, with `sram_bus_oe`=1.
- R8: `sram_oe_n_oe` is 1 exactly when the device is enabled and `cfg_last_sram`=1. `sram_oe_n_o` always follows `sram_oe_n_in`.
- R9: When `cfg_dev_en`=0, the outputs `flag_oe`, `sram_bus_oe`, `sram_oe_n_oe` and `dq_oe` are all 0, and `casc_lho_o` and `casc_bho_o` are both 0.
- R10: A clock edge at which `cfg_extra_lat` differs from the previous setting in use flushes the delay line. The result sampled at that edge and every result still in flight are discarded. Their slots are delivered as no-search slots.
- R11: After reset, and before any search leaves the delay line, every delivery slot is a no-search slot: `flag_hit`=0, `flag_vld`=0 and `ack_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dev_en | input | 1 | Device enable |
| cfg_last_cascade | input | 1 | Device is last in the depth cascade |
| cfg_last_sram | input | 1 | Device is last on the SRAM bus |
| cfg_extra_lat | input | 3 | Extra flag latency in cycles |
| srch_done | input | 1 | A search completes this cycle |
| srch_hit | input | 1 | The completing search hit in this device |
| rd_ack_in | input | 1 | SRAM read acknowledge from the core |
| sram_drv | input | 1 | Core drives the SRAM bus this cycle |
| sram_addr_in | input | 22 | Core SRAM address |
| sram_ce_n_in | input | 1 | Core chip enable, active low |
| sram_we_n_in | input | 1 | Core write enable, active low |
| sram_ale_n_in | input | 1 | Core address latch enable, active low |
| sram_oe_n_in | input | 1 | Core SRAM output enable, active low |
| casc_lho_in | input | 2 | Local cascade output from core |
| casc_bho_in | input | 3 | Block cascade output from core |
| dq_oe_req | input | 1 | Core requests to drive the data bus |
| flag_hit | output | 1 | Delayed hit flag |
| flag_vld | output | 1 | Delayed valid flag |
| flag_oe | output | 1 | Enable for the hit and valid flags |
| ack_o | output | 1 | Delayed read acknowledge |
| sram_addr_o | output | 22 | SRAM address out |
| sram_ce_n_o | output | 1 | SRAM chip enable out |
| sram_we_n_o | output | 1 | SRAM write enable out |
| sram_ale_n_o | output | 1 | SRAM address latch enable out |
| sram_bus_oe | output | 1 | Enable for address, CE, WE, ALE |
| sram_oe_n_o | output | 1 | SRAM output enable strobe |
| sram_oe_n_oe | output | 1 | Enable for the SRAM output enable strobe |
| casc_lho_o | output | 2 | Gated local cascade output |
| casc_bho_o | output | 3 | Gated block cascade output |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The stimulus is a random mix of hit searches, failed searches, idle cycles and read acknowledges. It is applied under every latency value and under every combination of the cascade and bus flags. Together these cases separate the own-hit response, the default-driver response for a failed search and the default-driver response for an idle cycle. Rare latency changes while results are still in flight show whether a flush discards stale results or lets them leak out at the wrong depth. The bus-driving and bus-idle cycles, combined with device enable toggled off, separate the default address and strobe values, the pass-through of the core's values and the fully released state.

// File: rtl/rfs_pkg.sv
// Package rfs_pkg
// Shared types for the result flag output stage.
// Assumes: one record per clock cycle enters the delay line.
package rfs_pkg;

    // one delivery slot: search completed, own hit, read acknowledge
    typedef struct packed {
        logic done;
        logic own;
        logic ack;
    } slot_t;

    localparam slot_t SLOT_IDLE = '{done: 1'b0, own: 1'b0, ack: 1'b0};

endpackage

// File: rtl/rfs_delay_line.sv
// Module rfs_delay_line
// Shift register of DEPTH slots. The tap index equals the latency setting
// in use. A change of the setting clears every stage (flush) and discards
// the slot offered on that edge.
// Assumes: DEPTH is a power of two and LAT_W = log2(DEPTH).
module rfs_delay_line
    import rfs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LAT_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] lat_sel,
    input  slot_t            slot_in,
    output slot_t            slot_out
);

    slot_t            stage [DEPTH];
    logic [LAT_W-1:0] lat_q;
    logic             flush;

    // a new latency value empties the pipeline
    assign flush = (lat_sel != lat_q);

    // register the latency value in use
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_sel;
    end

    // first stage captures the incoming slot
    always_ff @(posedge clk) begin
        if (!rst_n || flush) stage[0] <= SLOT_IDLE;
        else                 stage[0] <= slot_in;
    end

    // remaining stages shift one position per cycle
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n || flush) stage[g] <= SLOT_IDLE;
            else                 stage[g] <= stage[g-1];
        end
    end

    // tap at the depth selected by the registered latency
    assign slot_out = stage[lat_q];

endmodule

// File: rtl/rfs_sram_drv.sv
// Module rfs_sram_drv
// SRAM bus output logic. The core's values pass through while it owns the
// bus. The last device on the bus drives idle defaults otherwise, and it
// alone enables the output-enable strobe.
// Assumes: the core raises sram_drv only in cycles it owns the bus.
module rfs_sram_drv #(
    parameter int ADDR_W = 22
) (
    input  logic              dev_en,
    input  logic              last_sram,
    input  logic              sram_drv,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ce_n_in,
    input  logic              we_n_in,
    input  logic              ale_n_in,
    input  logic              oe_n_in,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ce_n_o,
    output logic              we_n_o,
    output logic              ale_n_o,
    output logic              bus_oe,
    output logic              oe_n_o,
    output logic              oe_n_oe
);

    // choose between the core's values and the idle defaults
    always_comb begin
        if (sram_drv) begin
            addr_o  = addr_in;
            ce_n_o  = ce_n_in;
            we_n_o  = we_n_in;
            ale_n_o = ale_n_in;
        end else begin
            addr_o  = '1;
            ce_n_o  = 1'b1;
            we_n_o  = 1'b1;
            ale_n_o = 1'b1;
        end
    end

    // enable the drivers only when this device owns the bus or is default
    assign bus_oe  = dev_en & (sram_drv | last_sram);
    assign oe_n_o  = oe_n_in;
    assign oe_n_oe = dev_en & last_sram;

endmodule

// File: rtl/rfs_casc_gate.sv
// Module rfs_casc_gate
// Forces the cascade outputs low and releases the data bus while the
// device is disabled.
// Assumes: nothing beyond a stable enable within a cycle.
module rfs_casc_gate #(
    parameter int LHO_W = 2,
    parameter int BHO_W = 3
) (
    input  logic             dev_en,
    input  logic [LHO_W-1:0] lho_in,
    input  logic [BHO_W-1:0] bho_in,
    input  logic             dq_req,
    output logic [LHO_W-1:0] lho_o,
    output logic [BHO_W-1:0] bho_o,
    output logic             dq_oe
);

    // gate each cascade bit with the device enable
    assign lho_o = dev_en ? lho_in : '0;
    assign bho_o = dev_en ? bho_in : '0;
    assign dq_oe = dev_en & dq_req;

endmodule

// File: rtl/result_flag_stage.sv
// Module result_flag_stage
// Output stage for the hit/valid flags and the read acknowledge. It adds a
// programmable latency, applies the default-driver rules of the cascade
// and the SRAM bus, and applies device-enable gating.
// Assumes: cascade arbitration is done elsewhere. A non-last device drives
// the flags only for its own hit.
module result_flag_stage
    import rfs_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int LAT_W  = $clog2(DEPTH),
    parameter int ADDR_W = 22,
    parameter int LHO_W  = 2,
    parameter int BHO_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dev_en,
    input  logic              cfg_last_cascade,
    input  logic              cfg_last_sram,
    input  logic [LAT_W-1:0]  cfg_extra_lat,
    input  logic              srch_done,
    input  logic              srch_hit,
    input  logic              rd_ack_in,
    input  logic              sram_drv,
    input  logic [ADDR_W-1:0] sram_addr_in,
    input  logic              sram_ce_n_in,
    input  logic              sram_we_n_in,
    input  logic              sram_ale_n_in,
    input  logic              sram_oe_n_in,
    input  logic [LHO_W-1:0]  casc_lho_in,
    input  logic [BHO_W-1:0]  casc_bho_in,
    input  logic              dq_oe_req,
    output logic              flag_hit,
    output logic              flag_vld,
    output logic              flag_oe,
    output logic              ack_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              sram_ce_n_o,
    output logic              sram_we_n_o,
    output logic              sram_ale_n_o,
    output logic              sram_bus_oe,
    output logic              sram_oe_n_o,
    output logic              sram_oe_n_oe,
    output logic [LHO_W-1:0]  casc_lho_o,
    output logic [BHO_W-1:0]  casc_bho_o,
    output logic              dq_oe
);

    slot_t slot_new;
    slot_t slot_dly;

    // pack this cycle's strobes into one slot
    always_comb begin
        slot_new.done = srch_done;
        slot_new.own  = srch_done & srch_hit;
        slot_new.ack  = rd_ack_in;
    end

    rfs_delay_line #(
        .DEPTH (DEPTH),
        .LAT_W (LAT_W)
    ) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat_sel  (cfg_extra_lat),
        .slot_in  (slot_new),
        .slot_out (slot_dly)
    );

    // decode the delayed slot into flag values and their enable
    always_comb begin
        flag_hit = slot_dly.own;
        flag_vld = slot_dly.done & (slot_dly.own | cfg_last_cascade);
        flag_oe  = cfg_dev_en & (slot_dly.own | cfg_last_cascade);
        ack_o    = slot_dly.ack;
    end

    rfs_sram_drv #(
        .ADDR_W (ADDR_W)
    ) u_sram (
        .dev_en    (cfg_dev_en),
        .last_sram (cfg_last_sram),
        .sram_drv  (sram_drv),
        .addr_in   (sram_addr_in),
        .ce_n_in   (sram_ce_n_in),
        .we_n_in   (sram_we_n_in),
        .ale_n_in  (sram_ale_n_in),
        .oe_n_in   (sram_oe_n_in),
        .addr_o    (sram_addr_o),
        .ce_n_o    (sram_ce_n_o),
        .we_n_o    (sram_we_n_o),
        .ale_n_o   (sram_ale_n_o),
        .bus_oe    (sram_bus_oe),
        .oe_n_o    (sram_oe_n_o),
        .oe_n_oe   (sram_oe_n_oe)
    );

    rfs_casc_gate #(
        .LHO_W (LHO_W),
        .BHO_W (BHO_W)
    ) u_casc (
        .dev_en (cfg_dev_en),
        .lho_in (casc_lho_in),
        .bho_in (casc_bho_in),
        .dq_req (dq_oe_req),
        .lho_o  (casc_lho_o),
        .bho_o  (casc_bho_o),
        .dq_oe  (dq_oe)
    );

endmodule

// File: rtl/rfs_checker.sv
// Module rfs_checker
// Properties of result_flag_stage, attached to every instance by bind.
module rfs_checker #(
    parameter int ADDR_W = 22,
    parameter int LHO_W  = 2,
    parameter int BHO_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_dev_en,
    input logic              cfg_last_cascade,
    input logic              cfg_last_sram,
    input logic [2:0]        cfg_extra_lat,
    input logic              srch_done,
    input logic              srch_hit,
    input logic              sram_drv,
    input logic              flag_hit,
    input logic              flag_vld,
    input logic              flag_oe,
    input logic [ADDR_W-1:0] sram_addr_o,
    input logic              sram_ce_n_o,
    input logic              sram_we_n_o,
    input logic              sram_ale_n_o,
    input logic              sram_bus_oe,
    input logic              sram_oe_n_oe,
    input logic [LHO_W-1:0]  casc_lho_o,
    input logic [BHO_W-1:0]  casc_bho_o,
    input logic              dq_oe
);

    AST_LAT0_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_extra_lat == 3'd0 && $past(cfg_extra_lat) == 3'd0 && srch_done && srch_hit)
        |=> (flag_hit && flag_vld)); // R1

    AST_HIT_HAS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        flag_hit |-> flag_vld); // R3

    AST_NONLAST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_oe && !cfg_last_cascade) |-> flag_hit); // R6

    AST_BUS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dev_en && cfg_last_sram && !sram_drv) |->
        (sram_bus_oe && sram_addr_o == '1 && sram_ce_n_o && sram_we_n_o && sram_ale_n_o)); // R7

    AST_OE_STROBE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        sram_oe_n_oe |-> (cfg_dev_en && cfg_last_sram)); // R8

    AST_DISABLED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dev_en |-> (!flag_oe && !sram_bus_oe && !sram_oe_n_oe && !dq_oe &&
                         casc_lho_o == '0 && casc_bho_o == '0)); // R9

endmodule

bind result_flag_stage rfs_checker #(
    .ADDR_W (ADDR_W),
    .LHO_W  (LHO_W),
    .BHO_W  (BHO_W)
) u_rfs_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_dev_en       (cfg_dev_en),
    .cfg_last_cascade (cfg_last_cascade),
    .cfg_last_sram    (cfg_last_sram),
    .cfg_extra_lat    (cfg_extra_lat),
    .srch_done        (srch_done),
    .srch_hit         (srch_hit),
    .sram_drv         (sram_drv),
    .flag_hit         (flag_hit),
    .flag_vld         (flag_vld),
    .flag_oe          (flag_oe),
    .sram_addr_o      (sram_addr_o),
    .sram_ce_n_o      (sram_ce_n_o),
    .sram_we_n_o      (sram_we_n_o),
    .sram_ale_n_o     (sram_ale_n_o),
    .sram_bus_oe      (sram_bus_oe),
    .sram_oe_n_oe     (sram_oe_n_oe),
    .casc_lho_o       (casc_lho_o),
    .casc_bho_o       (casc_bho_o),
    .dq_oe            (dq_oe)
);

// File: tb/tb_result_flag_stage.sv
// Bench for result_flag_stage: seeded random stimulus plus directed corners.
module tb_result_flag_stage;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_dev_en, cfg_last_cascade, cfg_last_sram;
    logic [2:0]  cfg_extra_lat;
    logic        srch_done, srch_hit, rd_ack_in, sram_drv;
    logic [21:0] sram_addr_in;
    logic        sram_ce_n_in, sram_we_n_in, sram_ale_n_in, sram_oe_n_in;
    logic [1:0]  casc_lho_in;
    logic [2:0]  casc_bho_in;
    logic        dq_oe_req;
    logic        flag_hit, flag_vld, flag_oe, ack_o;
    logic [21:0] sram_addr_o;
    logic        sram_ce_n_o, sram_we_n_o, sram_ale_n_o, sram_bus_oe;
    logic        sram_oe_n_o, sram_oe_n_oe;
    logic [1:0]  casc_lho_o;
    logic [2:0]  casc_bho_o;
    logic        dq_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done_run = 1'b0;

    // model state: per-edge history, flush edge, latency in use
    logic h_done [16];
    logic h_hit  [16];
    logic h_ack  [16];
    int   edge_n;
    int   flush_e;
    int   m_lat;

    always #4 clk = ~clk;

    result_flag_stage dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at edge %0d", req, act, exp, edge_n);
        end
    endtask

    // expected delayed slot after the latest edge
    function automatic logic [2:0] exp_slot();
        int s;
        s = edge_n - m_lat;
        if (s <= flush_e) return 3'b000;
        return {h_done[s % 16], h_done[s % 16] & h_hit[s % 16], h_ack[s % 16]};
    endfunction

    // combinational checks on current inputs
    task automatic chk_comb();
        logic en;
        en = cfg_dev_en;
        chk("R7 bus_oe", sram_bus_oe, en & (sram_drv | cfg_last_sram));
        chk("R7 addr", sram_addr_o, sram_drv ? sram_addr_in : 22'h3FFFFF);
        chk("R7 strobes", {sram_ce_n_o, sram_we_n_o, sram_ale_n_o},
            sram_drv ? {sram_ce_n_in, sram_we_n_in, sram_ale_n_in} : 3'b111);
        chk("R8 oe strobe en", sram_oe_n_oe, en & cfg_last_sram);
        chk("R8 oe strobe val", sram_oe_n_o, sram_oe_n_in);
        chk("R9 cascade", {casc_lho_o, casc_bho_o}, en ? {casc_lho_in, casc_bho_in} : 5'd0);
        chk("R9 dq_oe", dq_oe, en & dq_oe_req);
    endtask

    // flag checks after an edge: R1 R2 R3 R4 R5 R6 R10
    task automatic chk_flags();
        logic [2:0] e;
        logic done_b, own_b, ack_b;
        e = exp_slot();
        done_b = e[2]; own_b = e[1]; ack_b = e[0];
        chk("R1 R3 flag_hit", flag_hit, own_b);
        chk("R4 R5 flag_vld", flag_vld, done_b & (own_b | cfg_last_cascade));
        chk("R6 flag_oe", flag_oe, cfg_dev_en & (own_b | cfg_last_cascade));
        chk("R2 ack", ack_o, ack_b);
    endtask

    // one clock: model update at the edge, flag check after it
    task automatic step();
        @(posedge clk);
        edge_n++;
        if (int'(cfg_extra_lat) != m_lat) begin
            flush_e = edge_n;          // R10 flush
            m_lat = int'(cfg_extra_lat);
        end
        h_done[edge_n % 16] = srch_done;
        h_hit[edge_n % 16]  = srch_hit;
        h_ack[edge_n % 16]  = rd_ack_in;
        @(negedge clk);
        chk_flags();
    endtask

    task automatic rand_in(input bit lat_too);
        srch_done     = ($urandom % 2) == 0;
        srch_hit      = ($urandom % 3) == 0;
        rd_ack_in     = ($urandom % 4) == 0;
        sram_drv      = ($urandom % 2) == 0;
        sram_addr_in  = 22'($urandom);
        {sram_ce_n_in, sram_we_n_in, sram_ale_n_in, sram_oe_n_in} = 4'($urandom);
        casc_lho_in   = 2'($urandom);
        casc_bho_in   = 3'($urandom);
        dq_oe_req     = 1'($urandom);
        if (($urandom % 8) == 0) cfg_dev_en = ($urandom % 4) != 0;
        if (($urandom % 16) == 0) cfg_last_cascade = 1'($urandom);
        if (($urandom % 16) == 0) cfg_last_sram = 1'($urandom);
        if (lat_too && ($urandom % 24) == 0) cfg_extra_lat = 3'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        rst_n = 1'b0;
        cfg_dev_en = 1'b1; cfg_last_cascade = 1'b1; cfg_last_sram = 1'b1;
        cfg_extra_lat = 3'd0;
        srch_done = 1'b0; srch_hit = 1'b0; rd_ack_in = 1'b0; sram_drv = 1'b0;
        sram_addr_in = '0; sram_ce_n_in = 1'b1; sram_we_n_in = 1'b1;
        sram_ale_n_in = 1'b1; sram_oe_n_in = 1'b1;
        casc_lho_in = '0; casc_bho_in = '0; dq_oe_req = 1'b0;
        edge_n = 0; flush_e = 0; m_lat = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state: idle slot, last device drives 0/0
        chk("R11 reset hit", flag_hit, 1'b0);
        chk("R11 reset vld", flag_vld, 1'b0);
        chk("R11 reset ack", ack_o, 1'b0);
        chk("R11 reset oe", flag_oe, 1'b1);

        // directed: maximum latency, single hit then a failed search
        cfg_extra_lat = 3'd7;
        step();
        srch_done = 1'b1; srch_hit = 1'b1; rd_ack_in = 1'b1;
        #1 chk_comb();
        step();
        srch_done = 1'b1; srch_hit = 1'b0; rd_ack_in = 1'b0;
        step();
        srch_done = 1'b0;
        for (int i = 0; i < 9; i++) step();

        // directed: latency change with results in flight (R10)
        cfg_extra_lat = 3'd3;
        srch_done = 1'b1; srch_hit = 1'b1;
        step(); step();
        cfg_extra_lat = 3'd1;
        for (int i = 0; i < 6; i++) step();

        // directed: non-last device, disabled device (R6, R9)
        cfg_last_cascade = 1'b0; cfg_last_sram = 1'b0;
        srch_done = 1'b1; srch_hit = 1'b0; sram_drv = 1'b0;
        #1 chk_comb();
        for (int i = 0; i < 3; i++) step();
        cfg_dev_en = 1'b0; dq_oe_req = 1'b1; casc_lho_in = 2'b11; casc_bho_in = 3'b111;
        #1 chk_comb();
        step();
        cfg_dev_en = 1'b1; cfg_last_cascade = 1'b1; cfg_last_sram = 1'b1;

        // seeded random run
        for (int i = 0; i < 3000; i++) begin
            rand_in(1'b1);
            #1 chk_comb();
            step();
        end
        done_run = 1'b1;
    end

    // watchdog and summary
    initial begin
        for (int c = 0; c < 20000 && !done_run; c++) @(posedge clk);
        if (!done_run) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule